// File: doc/BRIEF.md
# Two-Page Register File with Page Selection

This block holds a register space split into pages of eight-bit registers. An agent reaches it through one seven-bit address. At address zero sits a page-control register that is shared by every page. Writing that register chooses which page will answer every later access to the other addresses. An upstream bus controller, for example an I2C target, uses the block through a single-cycle write strobe with write data. It reads back through a combinational read-data port, so a byte can be returned in the same cycle the address is presented.

The number of pages and the register width are parameters. The default build has two pages of 128 registers each. The active page comes out as a port so that neighbouring logic can follow it. Every register resets to zero, and the active page resets to page 0.

Top module: `pagereg_file`

## Requirements
- R1: While reset is held and right after it is released, `activePage` is 0 and every address on every page reads 00h.
- R2: A write strobe at address 0 loads bit 0 of `wrData` into the active page. Bits 7..1 of the written value have no effect.
- R3: A read of address 0 returns the active page number in bit 0 and zeros in bits 7..1, whichever page is active.
- R4: A write strobe at an address from 1 to 127 updates only that register in the active page. The register at the same address on the other page keeps its value.
- R5: A read of an address from 1 to 127 returns the register of the active page at that address, including the edges 1 and 127.
- R6: A page change takes effect on the very next cycle. A write or read issued in the cycle directly after the page write already reaches the new page.
- R7: While `wrEn` is low, no register and no page selection changes, whatever `regAddr` and `wrData` hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state updates on the rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 7 | Register address; 0 is the page-control register |
| wrData | input | 8 | Data written on a strobe |
| wrEn | input | 1 | Single-cycle write strobe |
| rdData | output | 8 | Combinational read data for `regAddr` |
| activePage | output | 1 | Currently selected page |

## Verification
The assertions assume that `regAddr` and `wrData` are stable across each rising edge. They also assume that `wrEn` is a plain per-cycle strobe, so that a write followed by an unchanged address can be expected to read back the written byte. The bench changes every input only on the falling clock edge and lowers `wrEn` between its read phases. Each sample is taken shortly after the falling edge. This keeps the stimulus inside those assumptions, and the combinational read path has settled when it is sampled.

// File: rtl/pagereg_pkg.sv
package pagereg_pkg;

  // Strobes from the control side to the storage side, one cycle wide.
  typedef struct packed {
    logic pageWr;   // write aimed at the shared page-control register
    logic regWr;    // write aimed at an ordinary register
    logic ctlSel;   // current address is the page-control register
  } strobes_t;

endpackage

// File: rtl/pagereg_ctrl.sv
module pagereg_ctrl
  import pagereg_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int PAGE_W = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              wrEn,
  input  logic [PAGE_W-1:0] pageBits,
  output strobes_t          strobes,
  output logic [PAGE_W-1:0] activePage
);

  localparam logic [ADDR_W-1:0] CTRL_ADDR = '0;

  logic isCtrl;

  always_comb begin
    isCtrl          = (regAddr == CTRL_ADDR);
    strobes.ctlSel  = isCtrl;
    strobes.pageWr  = wrEn && isCtrl;
    strobes.regWr   = wrEn && !isCtrl;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activePage <= '0;
    end else if (strobes.pageWr) begin
      activePage <= pageBits;
    end
  end

endmodule

// File: rtl/pagereg_data.sv
module pagereg_data
  import pagereg_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 7,
  parameter int PAGES  = 2
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  strobes_t                  strobes,
  input  logic [ADDR_W-1:0]         regAddr,
  input  logic [DATA_W-1:0]         wrData,
  input  logic [$clog2(PAGES)-1:0]  activePage,
  output logic [DATA_W-1:0]         rdData
);

  localparam int REGS   = 1 << ADDR_W;
  localparam int PAGE_W = $clog2(PAGES);

  logic [DATA_W-1:0] pageRd [PAGES];

  for (genvar p = 0; p < PAGES; p++) begin : g_page
    logic [DATA_W-1:0] cells [REGS];
    logic              hit;

    assign hit = strobes.regWr && (activePage == PAGE_W'(p));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        for (int r = 0; r < REGS; r++) begin
          cells[r] <= '0;
        end
      end else if (hit) begin
        cells[regAddr] <= wrData;
      end
    end

    assign pageRd[p] = cells[regAddr];
  end

  always_comb begin
    if (strobes.ctlSel) begin
      rdData = {{(DATA_W-PAGE_W){1'b0}}, activePage};
    end else begin
      rdData = pageRd[activePage];
    end
  end

endmodule

// File: rtl/pagereg_file.sv
module pagereg_file
  import pagereg_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 7,
  parameter int PAGES  = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [ADDR_W-1:0]        regAddr,
  input  logic [DATA_W-1:0]        wrData,
  input  logic                     wrEn,
  output logic [DATA_W-1:0]        rdData,
  output logic [$clog2(PAGES)-1:0] activePage
);

  localparam int PAGE_W = $clog2(PAGES);

  strobes_t strobes;

  pagereg_ctrl #(
    .ADDR_W (ADDR_W),
    .PAGE_W (PAGE_W)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .regAddr    (regAddr),
    .wrEn       (wrEn),
    .pageBits   (wrData[PAGE_W-1:0]),
    .strobes    (strobes),
    .activePage (activePage)
  );

  pagereg_data #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .PAGES  (PAGES)
  ) u_data (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .regAddr    (regAddr),
    .wrData     (wrData),
    .activePage (activePage),
    .rdData     (rdData)
  );

endmodule

// File: rtl/pagereg_file_chk.sv
module pagereg_file_chk #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 7,
  parameter int PAGES  = 2
) (
  input logic                     clk,
  input logic                     rstN,
  input logic [ADDR_W-1:0]        regAddr,
  input logic [DATA_W-1:0]        wrData,
  input logic                     wrEn,
  input logic [DATA_W-1:0]        rdData,
  input logic [$clog2(PAGES)-1:0] activePage
);

  localparam int PAGE_W = $clog2(PAGES);

  AST_PAGE_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && regAddr == '0) |=> activePage == $past(wrData[PAGE_W-1:0])); // R2

  AST_PAGE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && regAddr == '0) |=> $stable(activePage)); // R7

  AST_CTRL_READ: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == '0) |-> rdData == {{(DATA_W-PAGE_W){1'b0}}, activePage}); // R3

  AST_WRITE_READBACK: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && regAddr != '0) ##1 $stable(regAddr) |-> rdData == $past(wrData)); // R4

  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn ##1 $stable(regAddr) |-> $stable(rdData)); // R7

endmodule

bind pagereg_file pagereg_file_chk #(
  .DATA_W (DATA_W),
  .ADDR_W (ADDR_W),
  .PAGES  (PAGES)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .regAddr    (regAddr),
  .wrData     (wrData),
  .wrEn       (wrEn),
  .rdData     (rdData),
  .activePage (activePage)
);

// File: tb/pagereg_file_tb.sv
module pagereg_file_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [6:0] regAddr = '0;
  logic [7:0] wrData = '0;
  logic       wrEn = 1'b0;
  logic [7:0] rdData;
  logic [0:0] activePage;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pagereg_file u_dut (
    .clk        (clk),
    .rstN       (rstN),
    .regAddr    (regAddr),
    .wrData     (wrData),
    .wrEn       (wrEn),
    .rdData     (rdData),
    .activePage (activePage)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a;
    wrData  = d;
    wrEn    = 1'b1;
  endtask

  task automatic rd(input logic [6:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    wrEn    = 1'b0;
    regAddr = a;
    #1;
    check(tag, int'(rdData), int'(exp));
  endtask

  task automatic t_reset();
    #1;
    check("R1 page in reset", int'(activePage), 0);
    @(negedge clk);
    rstN = 1'b1;
    rd(7'd0,   8'h00, "R1 ctrl after reset");
    rd(7'd1,   8'h00, "R1 reg1 page0");
    rd(7'd127, 8'h00, "R1 reg127 page0");
    wr(7'd0, 8'h01);
    rd(7'd64,  8'h00, "R1 reg64 page1");
    wr(7'd0, 8'h00);
    rd(7'd0,   8'h00, "R1 back to page0");
  endtask

  task automatic t_pageSelect();
    wr(7'd0, 8'hFF);
    rd(7'd0, 8'h01, "R3 ctrl read page1");
    check("R2 page from bit0 of FF", int'(activePage), 1);
    wr(7'd0, 8'hFE);
    rd(7'd0, 8'h00, "R3 ctrl read page0");
    check("R2 upper bits ignored", int'(activePage), 0);
  endtask

  task automatic t_isolation();
    wr(7'd5,   8'hA5);
    wr(7'd1,   8'h11);
    wr(7'd127, 8'h7F);
    wr(7'd0,   8'h01);
    wr(7'd5,   8'h5A);
    rd(7'd5,   8'h5A, "R5 page1 reg5");
    rd(7'd1,   8'h00, "R4 page1 reg1 untouched");
    rd(7'd127, 8'h00, "R4 page1 reg127 untouched");
    wr(7'd0,   8'h00);
    rd(7'd5,   8'hA5, "R4 page0 reg5 kept");
    rd(7'd1,   8'h11, "R5 page0 reg1");
    rd(7'd127, 8'h7F, "R5 page0 reg127");
  endtask

  task automatic t_backToBack();
    wr(7'd0, 8'h01);
    wr(7'd9, 8'h33);
    wr(7'd0, 8'h00);
    rd(7'd9, 8'h00, "R6 page0 reg9 not hit");
    wr(7'd0, 8'h01);
    rd(7'd9, 8'h33, "R6 write landed in page1");
    wr(7'd0, 8'h00);
    rd(7'd5, 8'hA5, "R6 back-to-back read page0");
  endtask

  task automatic t_noStrobe();
    @(negedge clk);
    wrEn    = 1'b0;
    regAddr = 7'd5;
    wrData  = 8'hEE;
    @(negedge clk);
    regAddr = 7'd0;
    wrData  = 8'h01;
    @(negedge clk);
    #1;
    check("R7 page unchanged", int'(activePage), 0);
    rd(7'd5, 8'hA5, "R7 reg5 unchanged");
  endtask

  initial begin
    t_reset();
    t_pageSelect();
    t_isolation();
    t_backToBack();
    t_noStrobe();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule